// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block drives the carrier-sense and collision outputs that a 10/100 Ethernet PHY presents to its MAC. It takes a transmit-activity flag, a receive-activity flag and three configuration bits: duplex, speed and heartbeat enable. All of these inputs share one reference clock and are assumed to be clean already. From them the block forms the two outputs. Carrier sense follows both directions of traffic in half duplex and only received traffic in full duplex. Collision flags overlap of transmit and receive in half duplex and is forced low in full duplex.

At 10 Mb/s, in half duplex with the heartbeat enabled, the block also performs the signal-quality-error test. After each transmission ends it raises the collision output for a fixed number of reference-clock cycles. That number is set by the parameter `HB_CYCLES`, for example 25 cycles at 25 MHz for about one microsecond. A new transmission starting during this pulse cancels it, and a fresh pulse follows when that transmission ends. A change of configuration ends any pending pulse.

Top module: `crscol_gen`

## Requirements
- R1: With `fullDuplex`=0 (half duplex), at either speed, `crs` is 1 in the cycle after any cycle in which `txActive` or `rxActive` is 1, and 0 after a cycle in which both are 0.
- R2: With `fullDuplex`=1, `crs` in the next cycle equals `rxActive`; `txActive` alone never raises it.
- R3: With `fullDuplex`=0, `col` is 1 in the cycle after any cycle in which `txActive` and `rxActive` are both 1.
- R4: With `fullDuplex`=1, `col` is 0 in the cycle after every cycle, at either speed and whatever the activity.
- R5: With `fullDuplex`=0, `speed100`=0 and `hbEnable`=1, a 1-to-0 transition of `txActive` makes `col` 1 for exactly `HB_CYCLES` consecutive cycles, starting at the output of the clock edge that samples `txActive`=0.
- R6: No heartbeat pulse appears when `speed100`=1 (100 Mb/s) or when `hbEnable`=0: `col` then reflects only transmit/receive overlap.
- R7: Both outputs are registered with one clock of latency, and a synchronous active-high `rst` drives `crs` and `col` to 0 on the next edge.
- R8: A new transmission that starts while a heartbeat pulse is pending ends the pulse on the next edge. When that transmission ends, a full `HB_CYCLES` pulse follows.
- R9: Changing `fullDuplex`, `speed100` or `hbEnable` while a heartbeat pulse is running removes the pulse from `col` on the next edge, and no remainder of it appears later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| txActive | input | 1 | Transmit activity present |
| rxActive | input | 1 | Receive activity present |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hbEnable | input | 1 | 1 = heartbeat (SQE test) enabled |
| crs | output | 1 | Carrier sense, registered |
| col | output | 1 | Collision, registered |

## Verification
Two sources can drive `col` in the same cycle: the heartbeat pulse and a genuine transmit/receive overlap. The bench provokes this by turning receive activity on and off while a heartbeat is still counting. It also restarts transmission in the middle of a pulse, which makes the cancel path and the overlap term act on the same edge. A behavioural model counts the pulse length with a plain integer and is compared with both outputs after every clock. This way a pulse that is too long, one that is not cancelled, or one that masks a real collision is caught in the exact cycle where it goes wrong.

// File: rtl/crscol_pkg.sv
package crscol_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic hbStart; // transmit just ended: load the heartbeat counter
    logic hbKill;  // heartbeat not allowed this cycle: clear the counter
  } hbStrobe_t;
endpackage

// File: rtl/crscol_ctrl.sv
module crscol_ctrl
  import crscol_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      txActive,
  input  logic      fullDuplex,
  input  logic      speed100,
  input  logic      hbEnable,
  output hbStrobe_t strobe
);
  logic txPrev;
  logic hbEligible;

  always_ff @(posedge clk) begin
    if (rst) txPrev <= 1'b0;
    else     txPrev <= txActive;
  end

  // Heartbeat exists only for 10 Mb/s half duplex with the test enabled.
  // Leaving that mode in any way drops eligibility, so the counter is
  // cleared on any configuration change.
  assign hbEligible    = !fullDuplex && !speed100 && hbEnable;
  assign strobe.hbKill  = !hbEligible || txActive;
  assign strobe.hbStart = txPrev && !txActive;

  AST_START_AFTER_TX: assert property (@(posedge clk) disable iff (rst)
    strobe.hbStart |-> $past(txActive)); // R5
endmodule

// File: rtl/crscol_dp.sv
module crscol_dp
  import crscol_pkg::*;
#(
  parameter int HB_CYCLES = 25
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      txActive,
  input  logic      rxActive,
  input  logic      fullDuplex,
  input  hbStrobe_t strobe,
  output logic      crs,
  output logic      col
);
  localparam int CNT_W = $clog2(HB_CYCLES + 1);
  localparam logic [CNT_W-1:0] HB_LOAD = CNT_W'(HB_CYCLES);

  logic [CNT_W-1:0] hbCnt;
  logic [CNT_W-1:0] hbCntNext;

  always_comb begin
    if (strobe.hbKill)       hbCntNext = '0;
    else if (strobe.hbStart) hbCntNext = HB_LOAD;
    else if (hbCnt != '0)    hbCntNext = hbCnt - 1'b1;
    else                     hbCntNext = hbCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hbCnt <= '0;
      crs   <= 1'b0;
      col   <= 1'b0;
    end else begin
      hbCnt <= hbCntNext;
      crs   <= rxActive || (!fullDuplex && txActive);
      col   <= !fullDuplex && ((txActive && rxActive) || (hbCntNext != '0));
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!crs && !col)); // R7
  AST_FD_NO_COL: assert property (@(posedge clk) disable iff (rst)
    fullDuplex |=> !col); // R4
  AST_FD_CRS_RX: assert property (@(posedge clk) disable iff (rst)
    fullDuplex |=> (crs == $past(rxActive))); // R2
  AST_HD_CRS_TX: assert property (@(posedge clk) disable iff (rst)
    (!fullDuplex && (txActive || rxActive)) |=> crs); // R1
  AST_HD_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (!fullDuplex && txActive && rxActive) |=> col); // R3
  AST_KILL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (strobe.hbKill && !(txActive && rxActive)) |=> !col); // R8
endmodule

// File: rtl/crscol_gen.sv
module crscol_gen #(
  parameter int HB_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic txActive,
  input  logic rxActive,
  input  logic fullDuplex,
  input  logic speed100,
  input  logic hbEnable,
  output logic crs,
  output logic col
);
  import crscol_pkg::*;

  hbStrobe_t strobe;

  crscol_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .txActive   (txActive),
    .fullDuplex (fullDuplex),
    .speed100   (speed100),
    .hbEnable   (hbEnable),
    .strobe     (strobe)
  );

  crscol_dp #(.HB_CYCLES(HB_CYCLES)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .txActive   (txActive),
    .rxActive   (rxActive),
    .fullDuplex (fullDuplex),
    .strobe     (strobe),
    .crs        (crs),
    .col        (col)
  );

  AST_NO_HB_100: assert property (@(posedge clk) disable iff (rst)
    (speed100 && !(txActive && rxActive)) |=> !col); // R6
  AST_NO_HB_OFF: assert property (@(posedge clk) disable iff (rst)
    (!hbEnable && !(txActive && rxActive)) |=> !col); // R6
  AST_CFG_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ($changed(fullDuplex) || $changed(speed100) || $changed(hbEnable)) &&
    !(txActive && rxActive) |=> !col); // R9
endmodule

// File: tb/test_crscol_gen.sv
module test_crscol_gen;
  localparam int HB = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txActive = 1'b0, rxActive = 1'b0;
  logic fullDuplex = 1'b0, speed100 = 1'b0, hbEnable = 1'b0;
  logic crs, col;

  int checks = 0;
  int errors = 0;
  string phase = "R7";
  bit armed = 1'b0;
  bit expCrs = 1'b0, expCol = 1'b0;
  int hbLeft = 0;
  bit txPrev = 1'b0;

  always #5 clk = ~clk;

  crscol_gen #(.HB_CYCLES(HB)) i_crscol_gen (
    .clk(clk), .rst(rst), .txActive(txActive), .rxActive(rxActive),
    .fullDuplex(fullDuplex), .speed100(speed100), .hbEnable(hbEnable),
    .crs(crs), .col(col)
  );

  // Behavioural reference: heartbeat is a countdown of remaining cycles.
  always @(posedge clk) begin
    if (rst) begin
      armed  = 1'b1;
      expCrs = 1'b0;
      expCol = 1'b0;
      hbLeft = 0;
      txPrev = 1'b0;
    end else begin
      if (fullDuplex || speed100 || !hbEnable || txActive) hbLeft = 0;
      else if (txPrev && !txActive) hbLeft = HB;
      else if (hbLeft > 0) hbLeft = hbLeft - 1;
      expCrs = rxActive || (!fullDuplex && txActive);
      expCol = !fullDuplex && ((txActive && rxActive) || hbLeft > 0);
      txPrev = txActive;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (crs !== expCrs) begin
        errors++;
        $display("FAIL %s crs: actual %b expected %b at %0t", phase, crs, expCrs, $time);
      end
      checks++;
      if (col !== expCol) begin
        errors++;
        $display("FAIL %s col: actual %b expected %b at %0t", phase, col, expCol, $time);
      end
    end
  end

  task automatic drive(input bit tx, input bit rx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      txActive = tx;
      rxActive = rx;
    end
  endtask

  task automatic mode(input bit fd, input bit s100, input bit hb);
    @(negedge clk); #1;
    fullDuplex = fd; speed100 = s100; hbEnable = hb;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [7:0] lfsr;
    lfsr = 8'hA5;
    phase = "R7";
    txActive = 1'b1; rxActive = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    txActive = 1'b0; rxActive = 1'b0;
    drive(0, 0, 3);
    // R1: half duplex carrier follows both directions, no heartbeat
    phase = "R1";
    mode(0, 0, 0);
    drive(1, 0, 4); drive(0, 0, 3); drive(0, 1, 4); drive(0, 0, 3);
    mode(0, 1, 0);
    drive(1, 0, 3); drive(0, 1, 2); drive(0, 0, 2);
    // R2: full duplex carrier follows receive only
    phase = "R2";
    mode(1, 0, 1);
    drive(1, 0, 4); drive(0, 1, 3); drive(1, 1, 2); drive(0, 0, 3);
    // R3: half duplex overlap
    phase = "R3";
    mode(0, 1, 0);
    drive(1, 1, 4); drive(1, 0, 1); drive(1, 1, 1); drive(0, 0, 3);
    // R4: full duplex never collides
    phase = "R4";
    mode(1, 1, 0);
    drive(1, 1, 5); drive(0, 0, 2);
    mode(1, 0, 1);
    drive(1, 1, 5); drive(0, 0, 2);
    // R5: heartbeat length, with receive overlap during the pulse
    phase = "R5";
    mode(0, 0, 1);
    drive(1, 0, 5); drive(0, 0, HB + 6);
    drive(1, 0, 3); drive(0, 0, 5); drive(0, 1, 4); drive(0, 0, HB);
    // R6: no heartbeat at 100 Mb/s or when disabled
    phase = "R6";
    mode(0, 1, 1);
    drive(1, 0, 5); drive(0, 0, HB + 4);
    mode(0, 0, 0);
    drive(1, 0, 5); drive(0, 0, HB + 4);
    // R8: restart during the pulse, with an overlapping receive
    phase = "R8";
    mode(0, 0, 1);
    drive(1, 0, 4); drive(0, 0, 10); drive(1, 1, 2); drive(1, 0, 2); drive(0, 0, HB + 5);
    // R9: configuration changes mid-pulse
    phase = "R9";
    drive(1, 0, 3); drive(0, 0, 6);
    mode(1, 0, 1); drive(0, 0, 3);
    mode(0, 0, 1); drive(0, 0, HB);
    drive(1, 0, 3); drive(0, 0, 6);
    mode(0, 1, 1); drive(0, 0, 3);
    mode(0, 0, 1); drive(0, 0, HB);
    drive(1, 0, 3); drive(0, 0, 6);
    mode(0, 0, 0); drive(0, 0, 3);
    mode(0, 0, 1); drive(0, 0, HB);
    // R3: mixed traffic in the heartbeat mode
    phase = "R3";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(lfsr[0] & lfsr[1], lfsr[2] & lfsr[5], 1 + lfsr[7:6] * 4);
    end
    drive(0, 0, HB + 2);
    // R7: reset mid-pulse
    phase = "R7";
    drive(1, 1, 2); drive(0, 0, 3);
    @(negedge clk); #1; rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0;
    drive(0, 0, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule